// File: doc/BRIEF.md
# Prescaled Multi-Mode Match Timer

This block is a counter/timer core for a microcontroller-class peripheral. A prescale counter divides the clock by a programmable amount. Each time it wraps, the main counter takes one step. The step is up, down or back-and-forth, depending on the selected counting mode. Four match channels compare the main counter against their own match values. On a match, each channel can raise a sticky flag, restart the counter, or halt it by clearing the run bit.

Software reaches the block through a plain synchronous register port: a write strobe, a word index and write data, with combinational read data for the addressed word. The raw match flags are also brought out as a vector for an interrupt controller. Flags are cleared by writing ones to a clear word. The direction of the main counter is held in a two-state machine with the states DIR_UP and DIR_DOWN:

- In the edge-aligned modes, the machine rests in DIR_UP.
- In the center-aligned modes, a step taken in DIR_UP at or beyond the turn value (match value 0) moves the machine to DIR_DOWN.
- A step taken in DIR_DOWN at zero moves it back to DIR_UP.
- A counter reset or a match restart forces DIR_UP.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads 0, the flag vector is 0 and the counter is in DIR_UP. Word indices: 0 control, 1 counter, 2 prescale limit, 3 prescale count, 4 match actions, 5..8 match values 0..3, 9 raw flags (read-only), 10 flag clear (write-only, reads 0).
- R2: While the run bit (control bit 0) is 0, neither the counter nor the prescale count changes, except by a software write or a counter reset.
- R3: While running, a step (tick) happens in a cycle where the prescale count equals the prescale limit; the prescale count then returns to 0, otherwise it increments. A limit of 0 gives a step every clock.
- R4: Writing control with bit 1 set clears the counter and the prescale count at that clock edge and forces DIR_UP. Bit 1 is not stored and reads 0; this clear wins over any other update.
- R5: Mode (control bits 6:4) 0 is edge-aligned up: each step adds 1, wrapping at the counter width. Encodings 3, 5 and 7 behave like mode 0.
- R6: Mode 1 is edge-aligned down: each step subtracts 1, and a step taken at 0 loads match value 0.
- R7: Modes 2, 4 and 6 are center-aligned. They count up to match value 0, turn to DIR_DOWN and count down to 0, then turn to DIR_UP. The step at the turn already moves one count in the new direction (to 1, or to turn value minus 1); a value of 0 at a turn holds.
- R8: Channel i matches when a step happens while the counter equals its match value. If action bit 3i is set, the match sets flag i. In mode 2 the flag is set only in DIR_DOWN, in mode 4 only in DIR_UP, and in all other modes always. Flags are sticky.
- R9: If action bit 3i+1 is set, a match on channel i loads the counter with 0 (or with match value 0 in mode 1) instead of stepping, and forces DIR_UP.
- R10: If action bit 3i+2 is set, a match on channel i holds the counter and clears the run bit, even against a control write in the same cycle. A restart on the same match still loads its value.
- R11: Writing word 10 clears every flag whose data bit is 1; zero bits leave flags unchanged, and writes to word 9 are ignored.
- R12: A flag set by a match and a clear of the same flag in the same cycle leave the flag set.
- R13: A software write to the counter or prescale count takes effect at that edge and wins over a step; match, limit and action words take effect at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | ADDR_W (4) | Word index for write and read |
| wr_data | input | CNT_W (32) | Write data |
| rd_data | output | CNT_W (32) | Read data of the addressed word, combinational |
| match_flags | output | NUM_CH (4) | Raw sticky match flags |

## Verification
The main function is tried with directed sequences:
- single-step prescaling, which separates the step condition from the plain clock;
- a center-aligned run with a small turn value, which shows whether the turnaround is off by one step;
- a down-count restart, which tells a load of zero from a load of the turn value;
- a set/clear collision, which shows which of the two has priority.

A long constrained-random phase then mixes mode changes, small match and limit values, counter resets, and random action and clear masks. This exposes mismatches in direction tracking, phase-qualified flagging and stop/restart priority against a bench model cycle by cycle. Reads of the limit, action, match and clear words after each directed phase confirm that writes land where they should and that the clear word reads 0.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        MODE_EDGE_UP  = 3'd0,
        MODE_EDGE_DN  = 3'd1,
        MODE_CTR_DN   = 3'd2,
        MODE_CTR_UP   = 3'd4,
        MODE_CTR_BOTH = 3'd6
    } mode_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    localparam int unsigned REG_CTRL   = 0;
    localparam int unsigned REG_COUNT  = 1;
    localparam int unsigned REG_PLIM   = 2;
    localparam int unsigned REG_PCNT   = 3;
    localparam int unsigned REG_ACT    = 4;
    localparam int unsigned REG_MATCH0 = 5;

    function automatic logic is_center(input logic [2:0] m);
        return (m == MODE_CTR_DN) || (m == MODE_CTR_UP) || (m == MODE_CTR_BOTH);
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clear,
    input  logic         wr_lim,
    input  logic         wr_cnt,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] lim,
    output logic [W-1:0] pcnt,
    output logic         tick
);

    assign tick = run && (pcnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lim <= '0;
        else if (wr_lim) lim <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pcnt <= '0;
        else if (clear)  pcnt <= '0;
        else if (wr_cnt) pcnt <= wr_data;
        else if (run)    pcnt <= tick ? '0 : pcnt + W'(1);
    end

    AST_PSC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear && !wr_cnt) |=> $stable(pcnt)); // R2

    AST_PSC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear && !wr_cnt) |=> (pcnt == '0)); // R3

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clear,
    input  logic         wr_cnt,
    input  logic [W-1:0] wr_data,
    input  logic [2:0]   mode,
    input  logic [W-1:0] top,
    input  logic         rst_hit,
    input  logic         stop_hit,
    output logic [W-1:0] cnt,
    output dir_e         dir
);

    dir_e         dir_nxt;
    logic [W-1:0] cnt_nxt;
    logic         centered;

    assign centered = is_center(mode);

    always_comb begin
        dir_nxt = dir;
        cnt_nxt = cnt;
        if (clear) begin
            dir_nxt = DIR_UP;
            cnt_nxt = '0;
        end else if (wr_cnt) begin
            cnt_nxt = wr_data;
        end else if (tick) begin
            if (rst_hit) begin
                dir_nxt = DIR_UP;
                cnt_nxt = (mode == MODE_EDGE_DN) ? top : '0;
            end else if (!stop_hit) begin
                if (!centered) begin
                    dir_nxt = DIR_UP;
                    if (mode == MODE_EDGE_DN)
                        cnt_nxt = (cnt == '0) ? top : cnt - W'(1);
                    else
                        cnt_nxt = cnt + W'(1);
                end else begin
                    unique case (dir)
                        DIR_UP: begin
                            if (cnt >= top) begin
                                dir_nxt = DIR_DOWN;
                                cnt_nxt = (cnt == '0) ? '0 : cnt - W'(1);
                            end else begin
                                cnt_nxt = cnt + W'(1);
                            end
                        end
                        DIR_DOWN: begin
                            if (cnt == '0) begin
                                dir_nxt = DIR_UP;
                                cnt_nxt = (top == '0) ? '0 : W'(1);
                            end else begin
                                cnt_nxt = cnt - W'(1);
                            end
                        end
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dir <= DIR_UP;
        else        dir <= dir_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear && !wr_cnt) |=> $stable(cnt)); // R2

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0 && dir == DIR_UP)); // R4

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == MODE_EDGE_UP && !rst_hit && !stop_hit && !clear && !wr_cnt)
        |=> (cnt == $past(cnt) + W'(1))); // R5

    AST_CTR_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && centered && dir == DIR_UP && cnt >= top && !rst_hit && !stop_hit
         && !clear && !wr_cnt) |=> (dir == DIR_DOWN)); // R7

    AST_RESTART_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rst_hit && !clear && !wr_cnt) |=> (dir == DIR_UP)); // R9

endmodule

// File: rtl/tmr_match.sv
module tmr_match
    import tmr_pkg::*;
#(
    parameter int unsigned W   = 32,
    parameter int unsigned NCH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic [W-1:0]          cnt,
    input  logic [2:0]            mode,
    input  dir_e                  dir,
    input  logic                  wr_act,
    input  logic [NCH-1:0]        wr_mr,
    input  logic                  wr_clr,
    input  logic [W-1:0]          wr_data,
    output logic [3*NCH-1:0]      act,
    output logic [NCH-1:0][W-1:0] mr,
    output logic                  rst_hit,
    output logic                  stop_hit,
    output logic [NCH-1:0]        flags
);

    localparam int unsigned ACT_W = 3 * NCH;

    logic           phase_ok;
    logic [NCH-1:0] hit, set, rh, sh;

    always_comb begin
        if (mode == MODE_CTR_DN)      phase_ok = (dir == DIR_DOWN);
        else if (mode == MODE_CTR_UP) phase_ok = (dir == DIR_UP);
        else                          phase_ok = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      act <= '0;
        else if (wr_act) act <= wr_data[ACT_W-1:0];
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [W-1:0] mr_q;
        logic         flag_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        mr_q <= '0;
            else if (wr_mr[i]) mr_q <= wr_data;
        end

        assign hit[i] = tick && (cnt == mr_q);
        assign set[i] = hit[i] && act[3*i] && phase_ok;
        assign rh[i]  = hit[i] && act[3*i+1];
        assign sh[i]  = hit[i] && act[3*i+2];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= set[i] | (flag_q & ~(wr_clr & wr_data[i]));
        end

        assign mr[i]    = mr_q;
        assign flags[i] = flag_q;

        AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i]); // R12

        AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_clr && wr_data[i] && !set[i]) |=> !flags[i]); // R11

        AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (!set[i] && !(wr_clr && wr_data[i])) |=> $stable(flags[i])); // R8
    end

    assign rst_hit  = |rh;
    assign stop_hit = |sh;

endmodule

// File: rtl/match_timer.sv
module match_timer
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  rd_data,
    output logic [NUM_CH-1:0] match_flags
);

    localparam int unsigned ACT_W     = 3 * NUM_CH;
    localparam int unsigned FLAG_ADDR = REG_MATCH0 + NUM_CH;
    localparam int unsigned CLR_ADDR  = FLAG_ADDR + 1;

    logic                        run;
    logic [2:0]                  mode;
    logic                        we_ctrl, clear, tick;
    logic                        rst_hit, stop_hit;
    logic [NUM_CH-1:0]           wr_mr;
    logic [CNT_W-1:0]            lim, pcnt, cnt;
    logic [ACT_W-1:0]            act;
    logic [NUM_CH-1:0][CNT_W-1:0] mr;
    dir_e                        dir;

    assign we_ctrl = wr_en && (addr == ADDR_W'(REG_CTRL));
    assign clear   = we_ctrl && wr_data[1];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_wmr
        assign wr_mr[i] = wr_en && (addr == ADDR_W'(REG_MATCH0 + i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run  <= 1'b0;
            mode <= 3'd0;
        end else begin
            if (we_ctrl) begin
                run  <= wr_data[0];
                mode <= wr_data[6:4];
            end
            if (stop_hit) run <= 1'b0;
        end
    end

    tmr_prescaler #(.W(CNT_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .clear   (clear),
        .wr_lim  (wr_en && (addr == ADDR_W'(REG_PLIM))),
        .wr_cnt  (wr_en && (addr == ADDR_W'(REG_PCNT))),
        .wr_data (wr_data),
        .lim     (lim),
        .pcnt    (pcnt),
        .tick    (tick)
    );

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clear    (clear),
        .wr_cnt   (wr_en && (addr == ADDR_W'(REG_COUNT))),
        .wr_data  (wr_data),
        .mode     (mode),
        .top      (mr[0]),
        .rst_hit  (rst_hit),
        .stop_hit (stop_hit),
        .cnt      (cnt),
        .dir      (dir)
    );

    tmr_match #(.W(CNT_W), .NCH(NUM_CH)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cnt      (cnt),
        .mode     (mode),
        .dir      (dir),
        .wr_act   (wr_en && (addr == ADDR_W'(REG_ACT))),
        .wr_mr    (wr_mr),
        .wr_clr   (wr_en && (addr == ADDR_W'(CLR_ADDR))),
        .wr_data  (wr_data),
        .act      (act),
        .mr       (mr),
        .rst_hit  (rst_hit),
        .stop_hit (stop_hit),
        .flags    (match_flags)
    );

    always_comb begin
        rd_data = '0;
        if (addr == ADDR_W'(REG_CTRL)) begin
            rd_data[0]   = run;
            rd_data[6:4] = mode;
        end else if (addr == ADDR_W'(REG_COUNT)) begin
            rd_data = cnt;
        end else if (addr == ADDR_W'(REG_PLIM)) begin
            rd_data = lim;
        end else if (addr == ADDR_W'(REG_PCNT)) begin
            rd_data = pcnt;
        end else if (addr == ADDR_W'(REG_ACT)) begin
            rd_data[ACT_W-1:0] = act;
        end else if (addr == ADDR_W'(FLAG_ADDR)) begin
            rd_data[NUM_CH-1:0] = match_flags;
        end
        for (int i = 0; i < NUM_CH; i++)
            if (addr == ADDR_W'(REG_MATCH0 + i)) rd_data = mr[i];
    end

    AST_STOP_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        stop_hit |=> !run); // R10

    AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !(wr_en && addr == ADDR_W'(REG_COUNT)) && !clear) |=> $stable(cnt)); // R2

endmodule

// File: tb/test_match_timer.sv
`timescale 1ns/1ps
module test_match_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  match_flags;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    match_timer i_match_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .match_flags(match_flags)
    );

    // bench model state
    bit          m_run, m_dir;
    logic [2:0]  m_mode;
    logic [31:0] m_cnt, m_plim, m_pcnt;
    logic [11:0] m_act;
    logic [31:0] m_mr [4];
    logic [3:0]  m_flags;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step(input bit we, input int a, input logic [31:0] d);
        bit tick, pok, rst, stp, clr, cen, n_dir;
        logic [3:0]  set;
        logic [31:0] n_cnt, top;
        tick = m_run && (m_pcnt == m_plim);
        pok  = (m_mode == 3'd2) ? m_dir : (m_mode == 3'd4) ? !m_dir : 1'b1;
        rst = 0; stp = 0; set = '0;
        for (int i = 0; i < 4; i++) begin
            bit hit;
            hit = tick && (m_cnt == m_mr[i]);
            set[i] = hit && m_act[3*i] && pok;
            rst |= hit && m_act[3*i+1];
            stp |= hit && m_act[3*i+2];
        end
        clr = we && a == 0 && d[1];
        cen = (m_mode == 3'd2) || (m_mode == 3'd4) || (m_mode == 3'd6);
        top = m_mr[0];
        n_cnt = m_cnt; n_dir = m_dir;
        if (clr) begin
            n_cnt = 0; n_dir = 0;
        end else if (we && a == 1) begin
            n_cnt = d;
        end else if (tick) begin
            if (rst) begin
                n_cnt = (m_mode == 3'd1) ? top : 0; n_dir = 0;
            end else if (!stp) begin
                if (!cen) begin
                    n_dir = 0;
                    if (m_mode == 3'd1) n_cnt = (m_cnt == 0) ? top : m_cnt - 1;
                    else                n_cnt = m_cnt + 1;
                end else if (!m_dir) begin
                    if (m_cnt >= top) begin n_dir = 1; n_cnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
                    else n_cnt = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin n_dir = 0; n_cnt = (top == 0) ? 0 : 1; end
                    else n_cnt = m_cnt - 1;
                end
            end
        end
        if (clr)                 m_pcnt = 0;
        else if (we && a == 3)   m_pcnt = d;
        else if (m_run)          m_pcnt = tick ? 0 : m_pcnt + 1;
        if (we && a == 0) begin m_run = d[0]; m_mode = d[6:4]; end
        if (stp) m_run = 0;
        if (we && a == 2) m_plim = d;
        if (we && a == 4) m_act = d[11:0];
        if (we && a >= 5 && a <= 8) m_mr[a-5] = d;
        m_flags = (m_flags & ~((we && a == 10) ? d[3:0] : 4'h0)) | set;
        m_cnt = n_cnt; m_dir = n_dir;
    endtask

    function automatic logic [31:0] ctrl_exp();
        return {25'd0, m_mode, 3'd0, m_run};
    endfunction

    task automatic peek(input int a, output logic [31:0] v);
        addr = a[3:0];
        #0.2;
        v = rd_data;
    endtask

    // one clock: drive at negedge, check after posedge
    task automatic cyc(input bit we, input int a, input logic [31:0] d);
        logic [31:0] v;
        @(negedge clk);
        wr_en = we; addr = a[3:0]; wr_data = d;
        model_step(we, a, d);
        @(posedge clk);
        #0.3;
        wr_en = 1'b0;
        peek(1, v); chk("R5 R6 R7 R9 R13 count", v, m_cnt);
        peek(3, v); chk("R3 prescale count", v, m_pcnt);
        peek(0, v); chk("R10 R4 control", v, ctrl_exp());
        chk("R8 R11 R12 flags", {28'd0, match_flags}, {28'd0, m_flags});
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 0, 32'd0);
    endtask

    // full register sweep while frozen (run must be 0)
    task automatic sweep(input string tag);
        logic [31:0] v;
        @(negedge clk);
        peek(0, v);  chk({tag, " R1 ctrl"}, v, ctrl_exp());
        peek(1, v);  chk({tag, " R1 count"}, v, m_cnt);
        peek(2, v);  chk({tag, " R13 limit"}, v, m_plim);
        peek(3, v);  chk({tag, " R1 pcount"}, v, m_pcnt);
        peek(4, v);  chk({tag, " R13 actions"}, v, {20'd0, m_act});
        for (int i = 0; i < 4; i++) begin
            peek(5 + i, v); chk({tag, " R13 match value"}, v, m_mr[i]);
        end
        peek(9, v);  chk({tag, " R8 flag word"}, v, {28'd0, m_flags});
        peek(10, v); chk({tag, " R11 clear word reads 0"}, v, 32'd0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    function automatic logic [2:0] pick_mode(input int r);
        case (r % 6)
            0: return 3'd0; 1: return 3'd1; 2: return 3'd2;
            3: return 3'd4; 4: return 3'd6; default: return 3'd5;
        endcase
    endfunction

    initial begin
        logic [31:0] rv;
        rv = $urandom(32'd20240611);
        m_run = 0; m_dir = 0; m_mode = 0; m_cnt = 0; m_plim = 0; m_pcnt = 0;
        m_act = 0; m_flags = 0;
        for (int i = 0; i < 4; i++) m_mr[i] = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: reset state
        sweep("reset");
        chk("R1 flag vector at reset", {28'd0, match_flags}, 32'd0);

        // R2: stopped timer ignores time
        cyc(1, 2, 32'd0);
        idle(4);
        chk("R2 count frozen while stopped", m_cnt, 32'd0);

        // R3 + R5: limit 0 steps each clock, then limit 2
        cyc(1, 0, 32'h0000_0001);
        idle(5);
        chk("R3 R5 limit 0 gives one step per clock", m_cnt, 32'd5);
        cyc(1, 2, 32'd2);
        idle(9);

        // R4: counter reset
        cyc(1, 0, 32'h0000_0003);
        chk("R4 counter reset clears count", m_cnt, 32'd0);
        idle(3);

        // R7: center-aligned, turn value 4, flags both phases on ch1 value 2
        cyc(1, 2, 32'd0);
        cyc(1, 5, 32'd4);
        cyc(1, 6, 32'd2);
        cyc(1, 4, 32'h0000_0008);
        cyc(1, 0, 32'h0000_0063);
        idle(20);

        // R12: set and clear collide
        cyc(1, 10, 32'hF);
        while (m_cnt != 32'd2) idle(1);
        cyc(1, 10, 32'h2);
        chk("R12 set wins over clear", {31'd0, m_flags[1]}, 32'd1);
        // R11: writing 0 leaves flag, writing 1 clears
        cyc(1, 0, 32'h0000_0000);
        cyc(1, 10, 32'h0);
        chk("R11 zero clear has no effect", {31'd0, match_flags[1]}, 32'd1);
        cyc(1, 9, 32'h0);
        cyc(1, 10, 32'h2);
        chk("R11 one clears flag", {31'd0, match_flags[1]}, 32'd0);
        sweep("center");

        // R9: restart in down mode loads turn value
        cyc(1, 1, 32'd9);
        cyc(1, 5, 32'd12);
        cyc(1, 7, 32'd6);
        cyc(1, 4, 32'h0000_0080);
        cyc(1, 0, 32'h0000_0011);
        idle(12);

        // R10: stop action, with same-cycle run write
        cyc(1, 0, 32'h0000_0003);
        cyc(1, 8, 32'd3);
        cyc(1, 4, 32'h0000_0800);
        idle(2);
        cyc(1, 0, 32'h0000_0001);
        idle(6);
        chk("R10 stop clears run", {31'd0, m_run}, 32'd0);
        chk("R10 stop holds count", m_cnt, 32'd3);
        sweep("stop");

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            int a;
            logic [31:0] d;
            if ($urandom % 4 != 0) begin
                idle(1);
            end else begin
                a = $urandom % 11;
                case (a)
                    0: d = {25'd0, pick_mode($urandom), 2'd0, ($urandom % 16 == 0), ($urandom % 8 != 0)};
                    1: d = $urandom % 24;
                    2, 3: d = $urandom % 3;
                    4: d = $urandom % 4096;
                    5, 6, 7, 8: d = $urandom % 20;
                    default: d = $urandom % 16;
                endcase
                cyc(1, a, d);
            end
        end
        cyc(1, 0, 32'h0);
        sweep("random");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            summary();
            $finish;
        end
    end

endmodule